// File: doc/BRIEF.md
# Serial PHY Management Master

This block is the master side of the two-wire management bus used to read and write 16-bit registers inside Ethernet PHYs. A host presents one request at a time: a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the management clock and runs a complete frame. The data pin is bidirectional. It is split into an output value, an output enable and an input, so that the pad cell stays outside the block.

Every frame is 65 clock pulses long. The first 32 are a preamble with the line driven high. The next 14 carry the header, most significant bit first: a start pattern, an opcode and the two addresses. A write then drives a turnaround pattern, the 16 data bits and one idle pulse. A read releases the line at that point and gives one idle pulse. On the next pulse the master samples an acknowledge bit, which a responding PHY pulls low. It then clocks 16 data slots and finishes with one trailing pulse. When no PHY acknowledges, the 16 data slots are still clocked so that every PHY on the bus stays aligned, and the read reports an error.

The management clock idles high. Each half of a clock period lasts `DIV_HALF` system clocks. Outgoing bits change when the clock falls. Incoming bits are sampled in the last system cycle before the clock rises.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever no transaction is running, `busy` and `done` are low, `mdc` is high and `mdio_oe` is low.
- R2: In frame slots 0 to 31 (slot k being the k-th rising edge of `mdc` after a start), `mdio_oe` and `mdio_o` are both high.
- R3: Slots 32 to 45 carry the header MSB first: start pattern 01, opcode (read 10, write 01), 5-bit PHY address, 5-bit register address, all with `mdio_oe` high.
- R4: In a write, slots 46–47 drive turnaround 10, slots 48–63 drive the write data MSB first, and slot 64 is an idle pulse driven high. `mdio_oe` then drops when the transaction ends.
- R5: In a read, `mdio_oe` and `mdio_o` are low from slot 46 through slot 64. `mdio_i` is ignored in slot 46 and sampled in slot 47 as the acknowledge bit, where low means a PHY responded.
- R6: In a read with a low acknowledge, `rd_data` takes the `mdio_i` values of slots 48 to 63, with slot 48 as bit 15, and `rd_err` is low.
- R7: In a read with a high acknowledge, all 65 slots are still clocked, `rd_data` is 0 and `rd_err` is high.
- R8: Every transaction produces exactly 65 `mdc` pulses, so a read ends with one trailing pulse after its last data slot.
- R9: During a transaction, `mdc` is low for `DIV_HALF` system clocks and high for `DIV_HALF` system clocks in every slot. `mdio_o` and `mdio_oe` change only in the cycle in which `mdc` falls, so a transaction keeps `busy` high for 130·`DIV_HALF` cycles.
- R10: `req_start` while `busy` is low is accepted, and `busy` rises in the next cycle. `req_start` while `busy` is high is ignored: the frame in progress and its length are unchanged, and no second frame follows.
- R11: `done` pulses for one cycle in the cycle `busy` falls, with the results already valid. A completed write reports `rd_err` low and leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| rd_err | output | 1 | Last read saw no acknowledge |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench sweeps every PHY address through writes and through acknowledged reads. It also runs reads that no PHY acknowledges, and compares every one of the 65 slots with a frame it builds by concatenation. Its PHY model holds the line high in the read idle slot. A design that sampled the acknowledge one slot early would therefore report an error on every read. A design that skipped the 16 data pulses after a missing acknowledge would show fewer than 65 pulses and a short busy window. Data words with a marked first or last bit show up a capture that is off by one slot, or that is reversed. A start request injected mid-frame would, if accepted, corrupt the rest of the frame or start a ghost transaction. A write that disturbed the read result would be caught by the readback after each write.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int PRE_LEN    = 32;
  localparam int FLD_W      = 5;
  localparam int DAT_W      = 16;
  localparam int HDR_LEN    = 4 + 2 * FLD_W;
  localparam int TA_FIRST   = PRE_LEN + HDR_LEN;
  localparam int ACK_SLOT   = TA_FIRST + 1;
  localparam int DATA_FIRST = TA_FIRST + 2;
  localparam int DATA_LAST  = DATA_FIRST + DAT_W - 1;
  localparam int LAST_SLOT  = DATA_LAST + 1;
  localparam int NSLOT      = LAST_SLOT + 1;
  localparam int SLOT_W     = $clog2(NSLOT);

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic             wr;
    logic [FLD_W-1:0] phy;
    logic [FLD_W-1:0] regad;
    logic [DAT_W-1:0] wdata;
  } mdio_req_t;

  typedef struct packed {
    logic oe;
    logic dout;
  } pin_drv_t;

  function automatic logic [HDR_LEN-1:0] header_bits(mdio_req_t r);
    return {SOF_PAT, (r.wr ? OP_WR : OP_RD), r.phy, r.regad};
  endfunction

  function automatic logic is_data_slot(slot_t s);
    return (int'(s) >= DATA_FIRST) && (int'(s) <= DATA_LAST);
  endfunction

  function automatic logic is_ack_slot(slot_t s);
    return int'(s) == ACK_SLOT;
  endfunction

  function automatic logic is_last_slot(slot_t s);
    return int'(s) == LAST_SLOT;
  endfunction

  // Pin drive for a given slot of the frame.
  function automatic pin_drv_t slot_drive(mdio_req_t r, slot_t s);
    pin_drv_t             d;
    int                   i;
    logic [HDR_LEN-1:0]   hdr;
    i      = int'(s);
    hdr    = header_bits(r);
    d.oe   = 1'b1;
    d.dout = 1'b1;
    if (i < PRE_LEN) begin
      d.dout = 1'b1;
    end else if (i < TA_FIRST) begin
      d.dout = hdr[HDR_LEN-1-(i-PRE_LEN)];
    end else if (!r.wr) begin
      d.oe   = 1'b0;
      d.dout = 1'b0;
    end else if (i < DATA_FIRST) begin
      d.dout = TA_WR[1-(i-TA_FIRST)];
    end else if (i <= DATA_LAST) begin
      d.dout = r.wdata[DAT_W-1-(i-DATA_FIRST)];
    end else begin
      d.dout = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/mdio_halfbit_timer.sv
module mdio_halfbit_timer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic sample_stb,
  output logic slot_end
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LIM = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          ph;      // 0: low half, 1: high half
  logic          at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (cnt == LIM) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_end     = run && (cnt == LIM);
  assign sample_stb = at_end && !ph;
  assign slot_end   = at_end && ph;
  assign mdc        = !run || ph;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_start,
  input  mdio_req_t req,
  input  logic      slot_end,
  output logic      run,
  output mdio_req_t cur,
  output slot_t     slot,
  output logic      accept,
  output logic      finish,
  output logic      mdio_o,
  output logic      mdio_oe
);
  pin_drv_t drv;

  assign accept = req_start && !run;
  assign finish = slot_end && is_last_slot(slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cur  <= '0;
      slot <= '0;
    end else if (accept) begin
      run  <= 1'b1;
      cur  <= req;
      slot <= '0;
    end else if (slot_end) begin
      if (is_last_slot(slot)) run <= 1'b0;
      else                    slot <= slot + 1'b1;
    end
  end

  assign drv     = slot_drive(cur, slot);
  assign mdio_oe = run && drv.oe;
  assign mdio_o  = run && drv.dout;

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sample_stb,
  input  slot_t            slot,
  input  logic             is_wr,
  input  logic             finish,
  input  logic             mdio_i,
  output logic [DAT_W-1:0] rd_data,
  output logic             rd_err,
  output logic             done
);
  logic             ack_hi;
  logic [DAT_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_hi <= 1'b1;
      shreg  <= '0;
    end else if (accept) begin
      ack_hi <= 1'b1;
      shreg  <= '0;
    end else if (sample_stb) begin
      if (is_ack_slot(slot))
        ack_hi <= mdio_i;
      else if (is_data_slot(slot) && !ack_hi)
        shreg <= {shreg[DAT_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        if (is_wr) begin
          rd_err <= 1'b0;
        end else begin
          rd_err  <= ack_hi;
          rd_data <= ack_hi ? '0 : shreg;
        end
      end
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_req_t req_in;
  mdio_req_t cur_req;
  slot_t     slot_idx;
  logic      run;
  logic      accept;
  logic      finish;
  logic      sample_stb;
  logic      slot_end;

  assign req_in = '{wr: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};

  mdio_halfbit_timer #(.HALF(DIV_HALF)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .mdc        (mdc),
    .sample_stb (sample_stb),
    .slot_end   (slot_end)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req       (req_in),
    .slot_end  (slot_end),
    .run       (run),
    .cur       (cur_req),
    .slot      (slot_idx),
    .accept    (accept),
    .finish    (finish),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  mdio_rx_capture u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .sample_stb (sample_stb),
    .slot       (slot_idx),
    .is_wr      (cur_req.wr),
    .finish     (finish),
    .mdio_i     (mdio_i),
    .rd_data    (rd_data),
    .rd_err     (rd_err),
    .done       (done)
  );

  assign busy = run;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_start,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data,
  input logic        rd_err,
  input slot_t       slot,
  input logic        cur_wr
);
  localparam int LW = $clog2(HALF + 2);
  logic [LW-1:0] lowlen;
  logic [LW-1:0] highlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowlen  <= '0;
      highlen <= '0;
    end else begin
      lowlen  <= (!mdc && lowlen  != {LW{1'b1}}) ? lowlen  + 1'b1 : (mdc  ? '0 : lowlen);
      highlen <= ( mdc && highlen != {LW{1'b1}}) ? highlen + 1'b1 : (!mdc ? '0 : highlen);
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc && !mdio_oe));

  assert_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(slot) < PRE_LEN) |-> (mdio_oe && mdio_o));

  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cur_wr && int'(slot) >= TA_FIRST) |-> (!mdio_oe && !mdio_o));

  assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_err) |-> (rd_data == 16'h0000));

  assert_frame_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'($past(slot)) == LAST_SLOT));

  assert_low_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && !$past(mdc)) |-> (int'(lowlen) == HALF));

  assert_high_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc && $past(mdc) && slot != '0) |-> (int'(highlen) == HALF));

  assert_pins_stable_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_start_gates_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_start));

  assert_busy_holds_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_wr));

  assert_done_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind mdio_master mdio_master_chk #(.HALF(DIV_HALF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_start (req_start),
  .busy      (busy),
  .done      (done),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .rd_data   (rd_data),
  .rd_err    (rd_err),
  .slot      (slot_idx),
  .cur_wr    (cur_req.wr)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int NS         = 65;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, rd_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // PHY model / monitor state
  int          rises = 0;
  int          bad_low = 0;
  int          lowcnt = 0;
  logic        mdc_prev = 1'b1;
  logic [NS-1:0] seen_oe, seen_o;
  logic        phy_ack = 1'b0;
  logic [15:0] phy_word = '0;
  logic [15:0] last_rd = '0;

  mdio_master #(.DIV_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic phy_level(int k);
    if (k == 47) return phy_ack ? 1'b0 : 1'b1;
    if (k >= 48 && k <= 63) return phy_ack ? phy_word[63 - k] : 1'b1;
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (!mdc) lowcnt++;
    if (mdc && !mdc_prev) begin
      if (rises < NS) begin
        seen_oe[rises] = mdio_oe;
        seen_o[rises]  = mdio_o;
      end
      if (lowcnt != HALF) bad_low++;
      lowcnt = 0;
      rises++;
    end
    if (!mdc && mdc_prev) mdio_i = phy_level(rises);
    mdc_prev = mdc;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", cycles, 200000);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // Compare a slot range of the observed frame against the expected vectors
  // (expected vectors hold slot 0 in their top bit).
  task automatic cmp_range(input logic [NS-1:0] eoe, input logic [NS-1:0] eo,
                           input int lo, input int hi, input string req);
    int bad = -1;
    for (int k = lo; k <= hi; k++)
      if (bad < 0 && (seen_oe[k] !== eoe[NS-1-k] || seen_o[k] !== eo[NS-1-k])) bad = k;
    if (bad < 0)
      check(1'b1, req, "frame slots", 0, 0);
    else
      check(1'b0, req, $sformatf("slot %0d oe,o", bad),
            {seen_oe[bad], seen_o[bad]}, {eoe[NS-1-bad], eo[NS-1-bad]});
  endtask

  task automatic run_txn(input logic wr, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input logic ack, input logic [15:0] word,
                         input logic inject);
    int blen = 0;
    int n = 0;
    logic [NS-1:0] eoe, eo;
    rises = 0; lowcnt = 0; bad_low = 0;
    phy_ack = ack; phy_word = word;
    seen_oe = '0; seen_o = '0;
    @(negedge clk);
    req_write = wr; req_phy = phy; req_reg = ra; req_wdata = wd; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    check(busy === 1'b1, "R10", "busy after start", busy, 1);
    blen = 1;
    while (n < 4000) begin
      n++;
      if (n == 57 && inject) begin
        req_write = ~wr; req_phy = ~phy; req_reg = ~ra; req_wdata = ~wd; req_start = 1'b1;
      end else begin
        req_start = 1'b0;
      end
      @(negedge clk);
      if (done) break;
      if (busy) blen++;
    end
    req_start = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R11", "done with busy low", {done, busy}, 2'b10);
    check(blen == 2 * NS * HALF, "R9", "busy cycles", blen, 2 * NS * HALF);
    check(bad_low == 0, "R9", "mdc low length errors", bad_low, 0);
    check(rises == NS, "R8", "mdc pulses", rises, NS);
    if (wr) begin
      eoe = {NS{1'b1}};
      eo  = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, wd, 1'b1};
    end else begin
      eoe = {{46{1'b1}}, 19'b0};
      eo  = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 19'b0};
    end
    cmp_range(eoe, eo, 0, 31, "R2");
    cmp_range(eoe, eo, 32, 45, "R3");
    cmp_range(eoe, eo, 46, 64, wr ? "R4" : "R5");
    if (wr) begin
      check(rd_err === 1'b0, "R11", "rd_err after write", rd_err, 0);
      check(rd_data === last_rd, "R11", "rd_data kept by write", rd_data, last_rd);
    end else if (ack) begin
      check(rd_err === 1'b0, "R6", "rd_err with ack", rd_err, 0);
      check(rd_data === word, "R6", "read data", rd_data, word);
      last_rd = word;
    end else begin
      check(rd_err === 1'b1, "R7", "rd_err without ack", rd_err, 1);
      check(rd_data === 16'h0, "R7", "rd_data without ack", rd_data, 0);
      last_rd = 16'h0;
    end
    repeat (3 * HALF + 2) @(negedge clk);
    check(busy === 1'b0 && rises == NS && mdc === 1'b1 && mdio_oe === 1'b0,
          inject ? "R10" : "R1", "idle after frame", {busy, mdc, mdio_oe}, 3'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    check(mdc === 1'b1 && mdio_oe === 1'b0, "R1", "pins in reset", {mdc, mdio_oe}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rd_data === 16'h0 && rd_err === 1'b0, "R1", "results after reset", {rd_err, rd_data}, 0);
    // Writes across every PHY address.
    for (int p = 0; p < 32; p++)
      run_txn(1'b1, 5'(p), 5'(p) ^ 5'h15, 16'(p * 16'h0925) ^ 16'hA5C3, 1'b1, 16'h0, 1'b0);
    // Acknowledged reads across every PHY address.
    for (int p = 0; p < 32; p++)
      run_txn(1'b0, 5'(p), 5'(31 - p), 16'h0, 1'b1, ~16'(p * 16'h1357), 1'b0);
    // Boundary data words.
    run_txn(1'b0, 5'h01, 5'h02, 16'h0, 1'b1, 16'h8000, 1'b0);
    run_txn(1'b0, 5'h01, 5'h03, 16'h0, 1'b1, 16'h0001, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h1F, 16'h0, 1'b1, 16'h0000, 1'b0);
    run_txn(1'b1, 5'h00, 5'h00, 16'h0000, 1'b1, 16'h0, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h1F, 16'h0, 1'b1, 16'hFFFF, 1'b0);
    // Reads that no PHY acknowledges.
    for (int p = 0; p < 4; p++)
      run_txn(1'b0, 5'(p * 7), 5'(p * 3), 16'h0, 1'b0, 16'hFFFF, 1'b0);
    run_txn(1'b0, 5'h04, 5'h05, 16'h0, 1'b1, 16'h5A3C, 1'b0);
    // Start requests during a busy frame.
    run_txn(1'b1, 5'h0A, 5'h11, 16'hC0DE, 1'b1, 16'h0, 1'b1);
    run_txn(1'b0, 5'h15, 5'h0A, 16'h0, 1'b1, 16'h1234, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule